// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block decides, once per clock, whether the interrupt level currently pending at a processor is accepted. When it is, it performs every processor state change of interrupt entry in the same clock edge. The enclosing core presents the pending level, the current interrupt level, a per-level source mask, the raised-interrupt and enable registers, its status word and its program counter. The block answers with a redirected program counter, an updated status word, the per-level saved-PC and saved-status registers, a cause register, an exception class and a one-cycle taken strobe.

Levels above 1 are high-priority interrupts. Each one saves the PC and the status word into a register pair of its own, raises the status word's interrupt level and jumps to its own vector. A level-1 interrupt instead becomes an ordinary exception: the user, kernel or double exception. The class depends on the exception-mode and user-mode bits of the status word. When the core has a dedicated double-exception PC register, a double exception saves its PC there. Vector targets can be relocated at run time through a base register.

Top module: `irq_entry_ctrl`

## Requirements
- R1: An interrupt is taken only when all three of these hold: the pending level (3 bits, 0 meaning none) is strictly greater than the current level; the pending level is at most NLEVELS; and the mask slice for that level ANDed with the raised and enable registers is nonzero. The slice for level L is bits [(L-1)*NSRC +: NSRC] of the mask bus.
- R2: Status word layout: bits [3:0] are the interrupt level, bit 4 is exception mode and bit 5 is user mode. When a level L above 1 is taken, the level-L saved-PC register receives the PC and the level-L saved-status register receives the status word. The new status word has its level field set to L, exception mode set, and all other bits kept. The class output is none (0) and the cause register is unchanged.
- R3: When level 1 is taken, the cause register becomes 4 and exception mode is set in the status word. Its level field and the other bits are unchanged.
- R4: When level 1 is taken with exception mode clear, the level-1 saved-PC register receives the PC. The class is user (1) and the user vector is used when user mode is set; otherwise the class is kernel (2) and the kernel vector is used.
- R5: When level 1 is taken with exception mode set, the class is double (3) and the double vector is used. With HAS_DBL_PC=1 the dedicated double-exception PC register receives the PC and the level-1 saved-PC register is unchanged.
- R6: With HAS_DBL_PC=0, a double exception saves the PC into the level-1 saved-PC register, and the double-exception PC register stays at zero.
- R7: Vector offsets from the base are 0x180+(L-2)*0x40 for level L, 0x300 for kernel, 0x340 for user and 0x3C0 for double. With RELOC_EN=1 the new PC is the offset plus the run-time base input. With RELOC_EN=0 it is the offset plus the fixed DFLT_VBASE.
- R8: All updates land in the single clock edge in which the take condition holds. The taken strobe is high for exactly the cycle after that edge. In a cycle where the condition fails, every register output holds its value.
- R9: After reset, every register output is zero and the taken strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_lvl_i | input | 3 | Pending interrupt level, 0 for none |
| cur_lvl_i | input | 4 | Current interrupt level of the core |
| lvl_mask_i | input | NLEVELS*NSRC | Source mask per level, level 1 in the lowest slice |
| intset_i | input | NSRC | Raised-interrupt register |
| inten_i | input | NSRC | Interrupt enable register |
| ps_i | input | XLEN | Current status word |
| pc_i | input | XLEN | Current program counter |
| vecbase_i | input | XLEN | Run-time vector base |
| pc_o | output | XLEN | Redirected program counter |
| ps_o | output | XLEN | Updated status word |
| epc_o | output | NLEVELS*XLEN | Saved-PC registers, level 1 in the lowest slice |
| eps_o | output | (NLEVELS-1)*XLEN | Saved-status registers, level 2 in the lowest slice |
| depc_o | output | XLEN | Double-exception PC register |
| cause_o | output | 6 | Cause register |
| exc_cls_o | output | 2 | Entry class: 0 none, 1 user, 2 kernel, 3 double |
| taken_o | output | 1 | One-cycle strobe after an accepted entry |

## Verification
High-priority entries are driven at a middle level and at the top level NLEVELS. Both show that the saved register pair is selected by level and that the vector offset scales with the level. Rejections cover four cases: a pending level equal to the current one, a level above NLEVELS with its source raised, a masked enable and a cleared raise bit. Together these separate the three terms of the take condition. Level-1 entries are driven with three status words (clear, user mode, exception mode), which tell the kernel, user and double paths apart. A second instance without a dedicated double PC and without relocation runs on the same stimulus. It shows where the double-exception PC goes and that the fixed base is used.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int LVL_W       = 3;
    localparam int IL_W        = 4;
    localparam int PS_EXCM_BIT = 4;
    localparam int PS_UM_BIT   = 5;
    localparam int CAUSE_W     = 6;

    localparam logic [CAUSE_W-1:0] CAUSE_LVL1 = 6'd4;

    localparam logic [31:0] OFS_LVL2     = 32'h0000_0180;
    localparam logic [31:0] OFS_LVL_STEP = 32'h0000_0040;
    localparam logic [31:0] OFS_KERNEL   = 32'h0000_0300;
    localparam logic [31:0] OFS_USER     = 32'h0000_0340;
    localparam logic [31:0] OFS_DOUBLE   = 32'h0000_03C0;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_USER   = 2'd1,
        CLS_KERNEL = 2'd2,
        CLS_DOUBLE = 2'd3
    } exc_cls_e;
endpackage

// File: rtl/irq_take_qual.sv
module irq_take_qual
    import irq_entry_pkg::*;
#(
    parameter int NLEVELS = 6,
    parameter int NSRC    = 16
) (
    input  logic [LVL_W-1:0]        pend_lvl_i,
    input  logic [IL_W-1:0]         cur_lvl_i,
    input  logic [NLEVELS*NSRC-1:0] lvl_mask_i,
    input  logic [NSRC-1:0]         intset_i,
    input  logic [NSRC-1:0]         inten_i,
    output logic                    take_o
);
    logic [NLEVELS:1] lvl_hit;
    logic             sel_hit;
    logic             above_cur;
    logic             in_range;

    // one reduction per configured level
    for (genvar l = 1; l <= NLEVELS; l++) begin : g_lvl
        assign lvl_hit[l] = |(lvl_mask_i[(l-1)*NSRC +: NSRC] & intset_i & inten_i);
    end

    always_comb begin
        sel_hit = 1'b0;
        for (int l = 1; l <= NLEVELS; l++) begin
            if (pend_lvl_i == LVL_W'(l)) begin
                sel_hit = lvl_hit[l];
            end
        end
    end

    assign above_cur = {1'b0, pend_lvl_i} > cur_lvl_i;
    assign in_range  = pend_lvl_i <= LVL_W'(NLEVELS);
    assign take_o    = above_cur && in_range && sel_hit;
endmodule

// File: rtl/irq_vec_reloc.sv
module irq_vec_reloc #(
    parameter int          XLEN       = 32,
    parameter bit          RELOC_EN   = 1'b1,
    parameter logic [31:0] DFLT_VBASE = 32'h4000_0000
) (
    input  logic [XLEN-1:0] ofs_i,
    input  logic [XLEN-1:0] vecbase_i,
    output logic [XLEN-1:0] tgt_o
);
    localparam logic [XLEN-1:0] FIXED_BASE = XLEN'(DFLT_VBASE);

    if (RELOC_EN) begin : g_reloc
        assign tgt_o = ofs_i + vecbase_i;
    end else begin : g_fixed
        logic unused_base;
        assign unused_base = ^vecbase_i;
        assign tgt_o = ofs_i + FIXED_BASE;
    end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int          NLEVELS    = 6,
    parameter int          NSRC       = 16,
    parameter int          XLEN       = 32,
    parameter bit          HAS_DBL_PC = 1'b1,
    parameter bit          RELOC_EN   = 1'b1,
    parameter logic [31:0] DFLT_VBASE = 32'h4000_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LVL_W-1:0]            pend_lvl_i,
    input  logic [IL_W-1:0]             cur_lvl_i,
    input  logic [NLEVELS*NSRC-1:0]     lvl_mask_i,
    input  logic [NSRC-1:0]             intset_i,
    input  logic [NSRC-1:0]             inten_i,
    input  logic [XLEN-1:0]             ps_i,
    input  logic [XLEN-1:0]             pc_i,
    input  logic [XLEN-1:0]             vecbase_i,
    output logic [XLEN-1:0]             pc_o,
    output logic [XLEN-1:0]             ps_o,
    output logic [NLEVELS*XLEN-1:0]     epc_o,
    output logic [(NLEVELS-1)*XLEN-1:0] eps_o,
    output logic [XLEN-1:0]             depc_o,
    output logic [CAUSE_W-1:0]          cause_o,
    output logic [1:0]                  exc_cls_o,
    output logic                        taken_o
);
    localparam int NEPS = NLEVELS - 1;

    typedef struct packed {
        logic [XLEN-1:0]               pc;
        logic [XLEN-1:0]               ps;
        logic [NLEVELS-1:0][XLEN-1:0]  epc;
        logic [NEPS-1:0][XLEN-1:0]     eps;
        logic [XLEN-1:0]               depc;
        logic [CAUSE_W-1:0]            cause;
        exc_cls_e                      cls;
        logic                          taken;
    } entry_st_t;

    entry_st_t       st_d, st_q;
    logic            take;
    logic            high_lvl;
    logic            cur_excm;
    logic            cur_um;
    logic [XLEN-1:0] ofs_sel;
    logic [XLEN-1:0] tgt_pc;

    irq_take_qual #(
        .NLEVELS (NLEVELS),
        .NSRC    (NSRC)
    ) u_qual (
        .pend_lvl_i (pend_lvl_i),
        .cur_lvl_i  (cur_lvl_i),
        .lvl_mask_i (lvl_mask_i),
        .intset_i   (intset_i),
        .inten_i    (inten_i),
        .take_o     (take)
    );

    assign high_lvl = pend_lvl_i > LVL_W'(1);
    assign cur_excm = ps_i[PS_EXCM_BIT];
    assign cur_um   = ps_i[PS_UM_BIT];

    // vector offset selection, before relocation
    always_comb begin
        if (high_lvl) begin
            ofs_sel = XLEN'(OFS_LVL2)
                    + (XLEN'(pend_lvl_i) - XLEN'(2)) * XLEN'(OFS_LVL_STEP);
        end else if (cur_excm) begin
            ofs_sel = XLEN'(OFS_DOUBLE);
        end else if (cur_um) begin
            ofs_sel = XLEN'(OFS_USER);
        end else begin
            ofs_sel = XLEN'(OFS_KERNEL);
        end
    end

    irq_vec_reloc #(
        .XLEN       (XLEN),
        .RELOC_EN   (RELOC_EN),
        .DFLT_VBASE (DFLT_VBASE)
    ) u_reloc (
        .ofs_i     (ofs_sel),
        .vecbase_i (vecbase_i),
        .tgt_o     (tgt_pc)
    );

    always_comb begin
        logic [XLEN-1:0] ps_nx;
        st_d       = st_q;
        st_d.taken = 1'b0;
        ps_nx      = ps_i;
        if (take) begin
            st_d.taken = 1'b1;
            st_d.pc    = tgt_pc;
            if (high_lvl) begin
                for (int l = 2; l <= NLEVELS; l++) begin
                    if (pend_lvl_i == LVL_W'(l)) begin
                        st_d.epc[l-1] = pc_i;
                        st_d.eps[l-2] = ps_i;
                    end
                end
                ps_nx[IL_W-1:0]      = IL_W'(pend_lvl_i);
                ps_nx[PS_EXCM_BIT]   = 1'b1;
                st_d.cls             = CLS_NONE;
            end else begin
                st_d.cause           = CAUSE_LVL1;
                ps_nx[PS_EXCM_BIT]   = 1'b1;
                if (cur_excm) begin
                    st_d.cls = CLS_DOUBLE;
                    if (HAS_DBL_PC) begin
                        st_d.depc = pc_i;
                    end else begin
                        st_d.epc[0] = pc_i;
                    end
                end else begin
                    st_d.epc[0] = pc_i;
                    st_d.cls    = cur_um ? CLS_USER : CLS_KERNEL;
                end
            end
            st_d.ps = ps_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o      = st_q.pc;
    assign ps_o      = st_q.ps;
    assign epc_o     = st_q.epc;
    assign eps_o     = st_q.eps;
    assign depc_o    = st_q.depc;
    assign cause_o   = st_q.cause;
    assign exc_cls_o = st_q.cls;
    assign taken_o   = st_q.taken;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
    import irq_entry_pkg::*;
#(
    parameter int NLEVELS = 6,
    parameter int XLEN    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LVL_W-1:0]   pend_lvl_i,
    input logic [IL_W-1:0]    cur_lvl_i,
    input logic [XLEN-1:0]    ps_i,
    input logic [XLEN-1:0]    pc_o,
    input logic [XLEN-1:0]    ps_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic [1:0]         exc_cls_o,
    input logic               taken_o
);
    AST_TAKE_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> ($past({1'b0, pend_lvl_i}) > $past(cur_lvl_i))); // R1
    AST_TAKE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> ($past(pend_lvl_i) <= LVL_W'(NLEVELS))); // R1
    AST_HIGH_LVL_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && exc_cls_o == CLS_NONE) |-> (ps_o[IL_W-1:0] == IL_W'($past(pend_lvl_i)))); // R2
    AST_EXCM_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> ps_o[PS_EXCM_BIT]); // R3
    AST_LVL1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && exc_cls_o != CLS_NONE) |-> (cause_o == CAUSE_LVL1)); // R3
    AST_USER_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && exc_cls_o == CLS_USER) |-> ($past(ps_i[PS_UM_BIT]) && !$past(ps_i[PS_EXCM_BIT]))); // R4
    AST_DOUBLE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && exc_cls_o == CLS_DOUBLE) |-> $past(ps_i[PS_EXCM_BIT])); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> ($stable(pc_o) && $stable(ps_o) && $stable(cause_o))); // R8
endmodule

bind irq_entry_ctrl irq_entry_chk #(
    .NLEVELS (NLEVELS),
    .XLEN    (XLEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_lvl_i (pend_lvl_i),
    .cur_lvl_i  (cur_lvl_i),
    .ps_i       (ps_i),
    .pc_o       (pc_o),
    .ps_o       (ps_o),
    .cause_o    (cause_o),
    .exc_cls_o  (exc_cls_o),
    .taken_o    (taken_o)
);

// File: tb/irq_entry_ctrl_tb.sv
`timescale 1ns/1ps
module irq_entry_ctrl_tb;
    localparam int NL = 6;
    localparam int NS = 16;
    localparam int XL = 32;
    localparam logic [31:0] VB = 32'h2000_0000;
    localparam logic [31:0] DF = 32'h4000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        pend = '0;
    logic [3:0]        cur = '0;
    logic [NL*NS-1:0]  mask;
    logic [NS-1:0]     iset = '1;
    logic [NS-1:0]     ien = '1;
    logic [XL-1:0]     ps = '0;
    logic [XL-1:0]     pc = '0;
    logic [XL-1:0]     vbase = VB;

    logic [XL-1:0]        pc_o, ps_o, depc_o, pc_a, ps_a, depc_a;
    logic [NL*XL-1:0]     epc_o, epc_a;
    logic [(NL-1)*XL-1:0] eps_o, eps_a;
    logic [5:0]           cause_o, cause_a;
    logic [1:0]           cls_o, cls_a;
    logic                 tk_o, tk_a;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // level L source is bit L of its slice
    always_comb begin
        mask = '0;
        for (int l = 1; l <= NL; l++) mask[(l-1)*NS + l] = 1'b1;
    end

    irq_entry_ctrl #(.NLEVELS(NL), .NSRC(NS), .XLEN(XL), .HAS_DBL_PC(1'b1),
                     .RELOC_EN(1'b1), .DFLT_VBASE(DF)) u_dut (
        .clk(clk), .rst_n(rst_n), .pend_lvl_i(pend), .cur_lvl_i(cur),
        .lvl_mask_i(mask), .intset_i(iset), .inten_i(ien), .ps_i(ps),
        .pc_i(pc), .vecbase_i(vbase), .pc_o(pc_o), .ps_o(ps_o),
        .epc_o(epc_o), .eps_o(eps_o), .depc_o(depc_o), .cause_o(cause_o),
        .exc_cls_o(cls_o), .taken_o(tk_o));

    irq_entry_ctrl #(.NLEVELS(NL), .NSRC(NS), .XLEN(XL), .HAS_DBL_PC(1'b0),
                     .RELOC_EN(1'b0), .DFLT_VBASE(DF)) u_alt (
        .clk(clk), .rst_n(rst_n), .pend_lvl_i(pend), .cur_lvl_i(cur),
        .lvl_mask_i(mask), .intset_i(iset), .inten_i(ien), .ps_i(ps),
        .pc_i(pc), .vecbase_i(vbase), .pc_o(pc_a), .ps_o(ps_a),
        .epc_o(epc_a), .eps_o(eps_a), .depc_o(depc_a), .cause_o(cause_a),
        .exc_cls_o(cls_a), .taken_o(tk_a));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // present one request for one edge, then return to idle
    task automatic fire(input logic [2:0] p, input logic [3:0] c,
                        input logic [31:0] s, input logic [31:0] a);
        @(negedge clk);
        pend = p; cur = c; ps = s; pc = a;
        @(negedge clk);
        pend = '0;
    endtask

    task automatic t_reset();
        chk("R9 pc", pc_o, 0);
        chk("R9 ps", ps_o, 0);
        chk("R9 taken", 32'(tk_o), 0);
        chk("R9 cause", 32'(cause_o), 0);
    endtask

    task automatic t_mid_level();
        fire(3'd3, 4'd1, 32'h21, 32'h1234);
        chk("R8 taken", 32'(tk_o), 1);
        chk("R7 reloc pc", pc_o, VB + 32'h1C0);
        chk("R7 fixed pc", pc_a, DF + 32'h1C0);
        chk("R2 ps", ps_o, 32'h33);
        chk("R2 epc3", epc_o[2*XL +: XL], 32'h1234);
        chk("R2 eps3", eps_o[1*XL +: XL], 32'h21);
        chk("R2 cls", 32'(cls_o), 0);
        chk("R2 cause kept", 32'(cause_o), 0);
    endtask

    task automatic t_hold();
        @(negedge clk);
        chk("R8 strobe drop", 32'(tk_o), 0);
        repeat (3) @(negedge clk);
        chk("R8 pc held", pc_o, VB + 32'h1C0);
        chk("R8 ps held", ps_o, 32'h33);
    endtask

    task automatic t_reject();
        fire(3'd2, 4'd2, 32'h0, 32'hAAAA);
        chk("R1 equal level", 32'(tk_o), 0);
        chk("R1 equal level pc", pc_o, VB + 32'h1C0);
        fire(3'd7, 4'd0, 32'h0, 32'hBBBB);
        chk("R1 above max", 32'(tk_o), 0);
        chk("R1 above max pc", pc_o, VB + 32'h1C0);
        @(negedge clk); ien = ~(16'h1 << 4);
        fire(3'd4, 4'd0, 32'h0, 32'hCCCC);
        chk("R1 disabled", 32'(tk_o), 0);
        chk("R1 disabled epc4", epc_o[3*XL +: XL], 0);
        ien = '1; iset = ~(16'h1 << 4);
        fire(3'd4, 4'd0, 32'h0, 32'hCCCC);
        chk("R1 not raised", 32'(tk_o), 0);
        chk("R1 not raised epc4", epc_o[3*XL +: XL], 0);
        iset = '1;
        fire(3'd1, 4'd1, 32'h0, 32'hDDDD);
        chk("R1 lvl1 masked by cur", 32'(tk_o), 0);
        chk("R1 lvl1 masked epc1", epc_o[0 +: XL], 0);
    endtask

    task automatic t_top_level();
        fire(3'd6, 4'd5, 32'h5, 32'h2222);
        chk("R2 top taken", 32'(tk_o), 1);
        chk("R7 top pc", pc_o, VB + 32'h280);
        chk("R2 top ps", ps_o, 32'h16);
        chk("R2 top epc6", epc_o[5*XL +: XL], 32'h2222);
        chk("R2 top eps6", eps_o[4*XL +: XL], 32'h5);
    endtask

    task automatic t_lvl1_kernel();
        fire(3'd1, 4'd0, 32'h0, 32'h500);
        chk("R3 cause", 32'(cause_o), 4);
        chk("R3 ps", ps_o, 32'h10);
        chk("R4 kernel cls", 32'(cls_o), 2);
        chk("R4 kernel pc", pc_o, VB + 32'h300);
        chk("R7 kernel fixed pc", pc_a, DF + 32'h300);
        chk("R4 epc1", epc_o[0 +: XL], 32'h500);
    endtask

    task automatic t_lvl1_user();
        fire(3'd1, 4'd0, 32'h23, 32'h600);
        chk("R4 user cls", 32'(cls_o), 1);
        chk("R4 user pc", pc_o, VB + 32'h340);
        chk("R3 user ps", ps_o, 32'h33);
        chk("R4 user epc1", epc_o[0 +: XL], 32'h600);
    endtask

    task automatic t_lvl1_double();
        fire(3'd1, 4'd0, 32'h10, 32'h700);
        chk("R5 dbl cls", 32'(cls_o), 3);
        chk("R5 dbl pc", pc_o, VB + 32'h3C0);
        chk("R5 depc", depc_o, 32'h700);
        chk("R5 epc1 kept", epc_o[0 +: XL], 32'h600);
        chk("R6 alt epc1", epc_a[0 +: XL], 32'h700);
        chk("R6 alt depc", depc_a, 0);
        chk("R6 alt cls", 32'(cls_a), 3);
        chk("R7 alt dbl pc", pc_a, DF + 32'h3C0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mid_level();
        t_hold();
        t_reject();
        t_top_level();
        t_lvl1_kernel();
        t_lvl1_user();
        t_lvl1_double();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule